// File: doc/BRIEF.md
# Transpose Buffer for a Two-Pass 8x8 Block Transform

This block joins the first (row-direction) pass of a separable 8x8 transform to the second (column-direction) pass. It accepts a stream of 16-bit coefficients, 64 per block, in row-major order on a valid/ready input port. It returns each block transposed on a valid/ready output port, so the second pass receives the columns of the first pass's result as consecutive groups of eight.

One storage array of 64 words serves both sides. Each cycle it accepts one write and one read, and a read of the location being written in that cycle sees the old word. The write side and the read side step through the array in the same address order. That order flips between row-major and column-major at every block boundary. Each location is therefore read out of block N before block N+1 is stored there. Once the first block has been filled, input and output can run at one word per cycle each without any gap.

The block does no arithmetic. Traversal orientation, block-full tracking and back-pressure are all handled inside it.

Top module: `xpose_buf`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: Input words are numbered 0..63 in arrival order within a block, with word i standing for row i/8, column i%8. The k-th word delivered for that block (k = 0..63) is input word (k%8)*8 + k/8.
- R3: `out_valid` is 1 exactly when more input blocks have been fully accepted than output blocks have been fully delivered. No word of a block is offered before its 64th input word is accepted.
- R4: `out_last` is 1 on the 64th word of every output block (k = 63), and 0 on every other word.
- R5: While a complete block awaits output, let w be the number of words of the next block accepted so far and r the number of words of the pending block delivered so far. `in_ready` is 1 only when w < r, or when w = r and `out_ready` is 1.
- R6: When a write and a read address the same location in one cycle, the read delivers the word of the older block. With `in_valid` and `out_ready` both held at 1, the block accepts and delivers one word per cycle once the first block is full.
- R7: Blocks keep their order and contents across any number of consecutive blocks and under any pattern of input gaps and output stalls. Each successive block is stored in the opposite traversal orientation to the one before.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Buffer can take the input word this cycle |
| in_data | input | DW (16) | Input coefficient, row-major within a block |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | DW (16) | Output coefficient, column-major within a block |
| out_last | output | 1 | Marks the 64th word of a block |

## Verification
Each input word carries its block number and its position, so any misplaced, lost or repeated word shows up at once in the transposed order. The bench runs this traffic under several regimes. Both sides run flat out, which keeps the write and read pointers on the same location for every cycle and so exercises the same-cycle old-data rule. Sparse input against a fast consumer keeps the writer well behind. A fast writer against a slow consumer pins the writer at the read pointer and separates correct stalling from overwriting unread data. Alternating bursts force the orientation to flip while stalls are in progress. Directed runs then fill a block against a blocked consumer, hold output mid-block, and reset in the middle of a block.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

  typedef enum logic {
    ORI_ROW = 1'b0,
    ORI_COL = 1'b1
  } ori_e;

  // Map a traversal index {major,minor} to a storage address.
  // Row orientation keeps the index; column orientation swaps the halves.
  function automatic logic [15:0] xp_map(input ori_e o, input logic [15:0] idx,
                                         input int unsigned lg);
    logic [15:0] msk, lo, hi;
    msk = (16'd1 << lg) - 16'd1;
    lo  = idx & msk;
    hi  = (idx >> lg) & msk;
    return (o == ORI_ROW) ? idx : ((lo << lg) | hi);
  endfunction

  function automatic ori_e xp_flip(input ori_e o);
    return (o == ORI_ROW) ? ORI_COL : ORI_ROW;
  endfunction

endpackage

// File: rtl/xpose_mem.sv
module xpose_mem #(
  parameter int DW    = 16,
  parameter int AW    = 6,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  // The write lands at the clock edge; the read is combinational, so a
  // same-cycle read of the written slot still returns the older word.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/xpose_wr_ctrl.sv
module xpose_wr_ctrl
  import xpose_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          pend,
  input  logic [AW-1:0] r_idx,
  input  logic          out_ready,
  output logic          in_ready,
  output logic [AW-1:0] w_idx,
  output ori_e          ori,
  output logic          blk_done
);

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic in_fire;

  // Behind a pending block the writer may reach the reader's slot only
  // when the reader vacates it in the same cycle.
  assign in_ready = !pend || (w_idx < r_idx) || ((w_idx == r_idx) && out_ready);
  assign in_fire  = in_valid && in_ready;
  assign blk_done = in_fire && (w_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_idx <= '0;
      ori   <= ORI_ROW;
    end else if (blk_done) begin
      w_idx <= '0;
      ori   <= xp_flip(ori);
    end else if (in_fire) begin
      w_idx <= w_idx + AW'(1);
    end
  end

  // R5: never step past the read pointer of the pending block
  p_no_overtake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && pend) |-> (w_idx <= r_idx));

  // R7: orientation flips at each completed input block
  p_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (ori != $past(ori)));

endmodule

// File: rtl/xpose_rd_ctrl.sv
module xpose_rd_ctrl #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_ready,
  input  logic          blk_done,
  output logic          pend,
  output logic [AW-1:0] r_idx,
  output logic          out_last
);

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic out_fire;
  logic rd_done;

  assign out_fire = pend && out_ready;
  assign rd_done  = out_fire && (r_idx == LAST);
  assign out_last = pend && (r_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      r_idx <= '0;
    end else begin
      if (blk_done)     pend <= 1'b1;
      else if (rd_done) pend <= 1'b0;
      if (rd_done)       r_idx <= '0;
      else if (out_fire) r_idx <= r_idx + AW'(1);
    end
  end

  // R3: output opens only after a write block has completed
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(blk_done));

  // R4: the flagged word ends the block and the read pointer wraps
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (r_idx == '0));

endmodule

// File: rtl/xpose_buf.sv
module xpose_buf
  import xpose_pkg::*;
#(
  parameter int DW = 16,
  parameter int N  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);

  localparam int LG    = $clog2(N);
  localparam int AW    = 2 * LG;
  localparam int DEPTH = N * N;

  logic [AW-1:0] w_idx, r_idx, waddr, raddr;
  ori_e          ori;
  logic          blk_done;
  logic          pend;
  logic          we;

  xpose_wr_ctrl #(.AW(AW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .pend     (pend),
    .r_idx    (r_idx),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .w_idx    (w_idx),
    .ori      (ori),
    .blk_done (blk_done)
  );

  xpose_rd_ctrl #(.AW(AW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_ready(out_ready),
    .blk_done (blk_done),
    .pend     (pend),
    .r_idx    (r_idx),
    .out_last (out_last)
  );

  // Both sides share one orientation: the pending block is read in the
  // order the following block is being written in.
  assign waddr = AW'(xp_map(ori, 16'(w_idx), LG));
  assign raddr = AW'(xp_map(ori, 16'(r_idx), LG));
  assign we    = in_valid && in_ready;

  xpose_mem #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (we),
    .waddr(waddr),
    .wdata(in_data),
    .raddr(raddr),
    .rdata(out_data)
  );

  assign out_valid = pend;

  // R8: a stalled output word is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/xpose_buf_tb.sv
module xpose_buf_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;

  always #10 clk = ~clk;

  xpose_buf u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  // {blocks, input-valid mask, output-ready mask}
  localparam logic [23:0] VEC [8] = '{
    {8'd3, 8'hFF, 8'hFF},
    {8'd2, 8'h55, 8'hFF},
    {8'd2, 8'hFF, 8'h55},
    {8'd3, 8'h0F, 8'hF0},
    {8'd2, 8'h81, 8'hFF},
    {8'd2, 8'hFF, 8'h11},
    {8'd3, 8'h3C, 8'hC3},
    {8'd1, 8'hFF, 8'hFF}
  };

  int nchk = 0, nfail = 0;
  int wb = 0, wi = 0, rb = 0, ri = 0;
  int cyc = 0;
  bit pv = 0, pr = 0;
  logic [15:0] pd = '0;

  function automatic logic [15:0] tag(input int b, input int i);
    return 16'((b << 6) | i);
  endfunction

  // output k of a block comes from input row k%8, column k/8
  function automatic int src_of(input int k);
    return (k % 8) * 8 + (k / 8);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit iv, input bit ordy);
    bit ifire, ofire, exp_rdy;
    @(negedge clk);
    cyc++;
    in_valid  = iv;
    in_data   = tag(wb, wi);
    out_ready = ordy;
    #1;
    chk(out_valid == (wb > rb), "R3 out_valid", 32'(out_valid), 32'(wb > rb));
    exp_rdy = (wb == rb) || (wi < ri) || ((wi == ri) && ordy);
    chk(in_ready == exp_rdy, "R5 in_ready", 32'(in_ready), 32'(exp_rdy));
    if (out_valid) begin
      chk(out_last == (ri == 63), "R4 out_last", 32'(out_last), 32'(ri == 63));
      if (pv && !pr)
        chk(out_data == pd, "R8 held data", 32'(out_data), 32'(pd));
    end
    ifire = iv && in_ready;
    ofire = out_valid && ordy;
    if (ofire) begin
      chk(out_data == tag(rb, src_of(ri)), "R2 R7 out_data",
          32'(out_data), 32'(tag(rb, src_of(ri))));
      ri++;
      if (ri == 64) begin ri = 0; rb++; end
    end
    if (ifire) begin
      wi++;
      if (wi == 64) begin wi = 0; wb++; end
    end
    pv = out_valid; pr = ordy; pd = out_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(out_last == 1'b0, "R1 out_last after reset", 32'(out_last), 32'd0);
    wb = 0; wi = 0; rb = 0; ri = 0; pv = 0; pr = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired, run hung");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    int acc;
    do_reset();

    // table walk: each entry streams whole blocks under its own throttling
    foreach (VEC[v]) begin
      int target = rb + int'(VEC[v][23:16]);
      int guard = 0;
      while (rb < target && guard < 4000) begin
        step(VEC[v][8 + (cyc % 8)] && (wb < target), VEC[v][(cyc * 3) % 8]);
        guard++;
      end
      chk(rb == target, "R7 blocks drained", 32'(rb), 32'(target));
    end

    // fill one block against a blocked consumer, then try to write more
    for (int i = 0; i < 64; i++) step(1'b1, 1'b0);
    chk(wb == rb + 1 && wi == 0, "R3 block filled", 32'(wb - rb), 32'd1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    chk(wi == 0, "R5 no write while reader stalled", 32'(wi), 32'd0);

    // both sides open: one in and one out every cycle, same slot each time
    acc = 0;
    for (int i = 0; i < 64; i++) begin
      step(1'b1, 1'b1);
      if (in_ready && out_valid) acc++;
    end
    chk(acc == 64, "R6 full-rate overlap", 32'(acc), 32'd64);

    // stall the output mid-block
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 60 && rb < wb; i++) step(1'b0, 1'b1);
    chk(rb == wb, "R8 drained after hold", 32'(rb), 32'(wb));

    // reset in the middle of a block, then run one clean block
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
    do_reset();
    for (int i = 0; i < 200 && rb < 1; i++) step(wb < 1, 1'b1);
    chk(rb == 1, "R1 block after mid-stream reset", 32'(rb), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule